// File: doc/BRIEF.md
# Front Panel Data Workspace Register

This block is an 8-bit editable holding register placed between a processor data bus and the data indicator lamps of an operator panel. While the processor is halted, a load command captures the byte currently on the bus. The operator can then force single bits to 1 or to 0 with per-bit strobes, and a deposit command drives the edited byte back onto the bus so that memory is overwritten.

While the processor runs, the lamps follow the live bus. The workspace is frozen during that time and is never driven onto the bus. Address generation and memory write timing belong to neighbouring blocks. Load, deposit and the set and clear strobes arrive as synchronous, debounced pulses that last one cycle.

Top module: `panel_data_ws`

## Requirements
- R1: While rst_ni is low, the workspace is 0x00. With run_i low, lamp_o reads 0x00, bus_drive_en_o is 0 and bus_drive_o is 0x00.
- R2: A load_i pulse with run_i low copies bus_data_i into the workspace at that clock edge. lamp_o shows the new value from the next cycle on.
- R3: A bit_set_i[n] pulse with run_i low and load_i low sets workspace bit n to 1.
- R4: A bit_clr_i[n] pulse with run_i low and load_i low clears workspace bit n to 0.
- R5: When bit_set_i[n] and bit_clr_i[n] are both high in the same cycle, bit n becomes 1.
- R6: When load_i is high, the set and clear strobes of that cycle have no effect. The workspace takes bus_data_i.
- R7: With run_i low and deposit_i high, bus_drive_en_o is 1 and bus_drive_o equals the workspace in that same cycle, with no register delay.
- R8: Whenever bus_drive_en_o is 0, bus_drive_o is 0x00.
- R9: While run_i is high, bus_drive_en_o is 0, even if deposit_i is high.
- R10: While run_i is high, lamp_o equals bus_data_i combinationally. With run_i low, lamp_o shows the workspace.
- R11: While run_i is high, load_i, bit_set_i and bit_clr_i are ignored. The workspace keeps its value across a run and shows on lamp_o once run_i falls.
- R12: Bits whose set and clear strobes are both low keep their value on an edit cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High while the processor runs |
| load_i | input | 1 | Capture the bus byte into the workspace |
| deposit_i | input | 1 | Drive the workspace onto the bus |
| bus_data_i | input | 8 | Data bus value |
| bit_set_i | input | 8 | Per-bit force-to-1 strobes |
| bit_clr_i | input | 8 | Per-bit force-to-0 strobes |
| lamp_o | output | 8 | Data indicator value |
| bus_drive_o | output | 8 | Value offered to the bus (0x00 when not driving) |
| bus_drive_en_o | output | 1 | Bus driver enable |

## Verification
Two functions can collide in one cycle: a load capture and a bit edit, or a set and a clear on the same bit. The bench provokes both. It raises load together with set and clear strobes, and it raises set and clear on the same bit in one cycle. After the edge it judges the result on lamp_o: the captured bus byte must win over the strobes, and set must win over clear. A third overlap, deposit together with load, is judged on bus_drive_o. In that cycle the driven value must be the workspace as it stands at the moment of sampling. Deposit and edits requested while running are also checked, to confirm they leave the bus undriven and the workspace untouched.

// File: rtl/panel_ws_pkg.sv
package panel_ws_pkg;
  localparam int unsigned WS_W = 8;
  typedef logic [WS_W-1:0] ws_word_t;
endpackage

// File: rtl/ws_bit_cell.sv
module ws_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic freeze_i,
  input  logic load_i,
  input  logic bus_bit_i,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  // load > set > clr; frozen while running
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_q <= 1'b0;
    else if (!freeze_i) begin
      if (load_i)       q_q <= bus_bit_i;
      else if (set_i)   q_q <= 1'b1;
      else if (clr_i)   q_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  // R5
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && !load_i && set_i) |=> q_o);
  // R6
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!freeze_i && load_i) |=> (q_o == $past(bus_bit_i)));
  // R11
  frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(q_o));
endmodule

// File: rtl/ws_lamp_mux.sv
module ws_lamp_mux #(
  parameter int unsigned W = 8
) (
  input  logic         run_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] lamp_o
);
  always_comb lamp_o = run_i ? live_i : held_i;
endmodule

// File: rtl/ws_bus_gate.sv
module ws_bus_gate #(
  parameter int unsigned W = 8
) (
  input  logic         run_i,
  input  logic         deposit_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] drive_o,
  output logic         drive_en_o
);
  // interlock: never drive while the processor owns the bus
  always_comb begin
    drive_en_o = deposit_i & ~run_i;
    drive_o    = drive_en_o ? held_i : '0;
  end
endmodule

// File: rtl/panel_data_ws.sv
module panel_data_ws
  import panel_ws_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           load_i,
  input  logic           deposit_i,
  input  logic [WS_W-1:0] bus_data_i,
  input  logic [WS_W-1:0] bit_set_i,
  input  logic [WS_W-1:0] bit_clr_i,
  output logic [WS_W-1:0] lamp_o,
  output logic [WS_W-1:0] bus_drive_o,
  output logic           bus_drive_en_o
);
  ws_word_t ws_q;

  for (genvar b = 0; b < WS_W; b++) begin : g_bit
    ws_bit_cell u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (run_i),
      .load_i   (load_i),
      .bus_bit_i(bus_data_i[b]),
      .set_i    (bit_set_i[b]),
      .clr_i    (bit_clr_i[b]),
      .q_o      (ws_q[b])
    );
  end

  ws_lamp_mux #(.W(WS_W)) u_lamp (
    .run_i (run_i),
    .live_i(bus_data_i),
    .held_i(ws_q),
    .lamp_o(lamp_o)
  );

  ws_bus_gate #(.W(WS_W)) u_gate (
    .run_i     (run_i),
    .deposit_i (deposit_i),
    .held_i    (ws_q),
    .drive_o   (bus_drive_o),
    .drive_en_o(bus_drive_en_o)
  );

  // R9
  run_blocks_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> !bus_drive_en_o);
  // R8
  idle_bus_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_drive_en_o |-> (bus_drive_o == '0));
  // R10
  run_lamp_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (lamp_o == bus_data_i));
  // R7
  deposit_matches_lamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && deposit_i) |-> (bus_drive_en_o && bus_drive_o == lamp_o));
endmodule

// File: tb/panel_data_ws_tb_top.sv
`timescale 1ns/1ps
module panel_data_ws_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0, load = 1'b0, dep = 1'b0;
  logic [7:0] bus = '0, set_s = '0, clr_s = '0;
  logic [7:0] lamp, drv;
  logic       en;
  int         n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  panel_data_ws dut_i (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .load_i(load), .deposit_i(dep),
    .bus_data_i(bus), .bit_set_i(set_s), .bit_clr_i(clr_s),
    .lamp_o(lamp), .bus_drive_o(drv), .bus_drive_en_o(en)
  );

  // {run,load,dep,bus,set,clr,exp_lamp,exp_en,exp_drv}; results sampled after the edge
  localparam int NV = 11;
  localparam logic [43:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,8'hA5,8'h00,8'h00,8'hA5,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,8'h02,8'h00,8'hA7,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,8'h00,8'h81,8'h26,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,8'h10,8'h10,8'h36,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h00,8'h0F,8'hF0,8'h0F,1'b0,8'h00},
    {1'b0,1'b1,1'b0,8'h5A,8'h01,8'h40,8'h5A,1'b0,8'h00},
    {1'b0,1'b0,1'b1,8'h00,8'h00,8'h00,8'h5A,1'b1,8'h5A},
    {1'b1,1'b1,1'b1,8'hC3,8'hFF,8'h00,8'hC3,1'b0,8'h00},
    {1'b1,1'b0,1'b0,8'h11,8'h00,8'hFF,8'h11,1'b0,8'h00},
    {1'b0,1'b0,1'b0,8'h77,8'h00,8'h00,8'h5A,1'b0,8'h00},
    {1'b0,1'b1,1'b1,8'h99,8'h00,8'h00,8'h99,1'b1,8'h99}
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";  1: return "R3";  2: return "R4";  3: return "R5";
      4: return "R12"; 5: return "R6";  6: return "R7";  7: return "R9";
      8: return "R10"; 9: return "R11"; default: return "R6";
    endcase
  endfunction

  task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1", "lamp", lamp, 8'h00);
    check("R1", "en", {7'b0, en}, 8'h00);
    check("R1", "drv", drv, 8'h00);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      run = VEC[i][43]; load = VEC[i][42]; dep = VEC[i][41];
      bus = VEC[i][40:33]; set_s = VEC[i][32:25]; clr_s = VEC[i][24:17];
      @(posedge clk); #1;
      check(tag_of(i), "lamp", lamp, VEC[i][16:9]);
      check(tag_of(i), "en", {7'b0, en}, {7'b0, VEC[i][8]});
      check(tag_of(i), "drv", drv, VEC[i][7:0]);
    end

    // R7 same-cycle drive, no register delay (workspace 0x99)
    @(negedge clk);
    load = 0; dep = 0; bus = 8'h00;
    @(negedge clk);
    dep = 1; #1;
    check("R7", "drv same cycle", drv, 8'h99);
    check("R8", "en same cycle", {7'b0, en}, 8'h01);
    dep = 0; #1;
    check("R8", "drv idle", drv, 8'h00);

    // R9 deposit while running, sampled before edge
    run = 1; dep = 1; bus = 8'h3C; #1;
    check("R9", "en while run", {7'b0, en}, 8'h00);
    check("R10", "lamp live", lamp, 8'h3C);
    bus = 8'hC0; #1;
    check("R10", "lamp follows bus", lamp, 8'hC0);
    @(negedge clk);
    run = 0; dep = 0; #1;
    check("R11", "retained after run", lamp, 8'h99);

    // R1 asynchronous reset mid-operation
    rst_n = 0; #1;
    check("R1", "lamp async reset", lamp, 8'h00);
    @(negedge clk) rst_n = 1;
    set_s = 8'h80;
    @(posedge clk); #1;
    check("R3", "set after reset", lamp, 8'h80);
    set_s = 8'h00;

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule